// File: doc/BRIEF.md
# Flash erase-verify sequencer

This block runs the erase of one or more flash blocks in hardware and then confirms that every word in each block reads back blank. A single start pulse launches the job. The caller supplies a mask of the blocks to erase, the first and last word address of each block, and six wait lengths given in clock cycles. The sequencer drives the array's mode controls: write enable, erase setup, erase pulse and verify mode. It also drives a one-hot block select. It reaches the array through a plain 16-bit port with address, write strobe, write data and read data.

Blocks are handled one at a time, in ascending index order. For each block the sequencer applies an erase pulse and releases erase mode. It then enters verify mode and walks the block's addresses. Each verify read is preceded by an all-ones dummy write that latches the address. If any word is not blank, the scan stops and the whole block goes through another erase pass. The number of passes is capped. When every selected block is blank, write enable is dropped and, after a final wait, done is raised. If a block is still not blank when the cap is reached, the job stops with fail and the index of that block.

Top module: `flash_erase_seq`

## Requirements
- R1: When start is sampled high in an idle, done or fail state with a non-zero mask, wr_en rises in the next cycle. erase_setup and erase_pulse rise together in that cycle, and erase_pulse stays high for wait_pulse cycles. Exactly one bit of blk_sel is high during that time.
- R2: After erase_pulse falls, erase_setup stays high alone for wait_hold cycles and then falls.
- R3: verify_mode rises as erase_setup falls. The first dummy write (arr_we high for one cycle) comes after wait_ventry cycles of verify_mode. Every dummy write carries arr_wdata = 16'hFFFF. Within a pass, dummy writes use consecutive addresses starting at the block's first address.
- R4: A verify read is taken wait_vread cycles after each dummy write, so consecutive dummy writes are wait_vread+2 cycles apart. verify_mode falls wait_vread+1 cycles after the last dummy write of a pass.
- R5: A read word that is not 16'hFFFF ends the scan of that pass. A read word of 16'hFFFF at the block's last address ends a successful pass. Either way, verify_mode falls and a gap of wait_vexit cycles follows, with wr_en high and the other mode controls low. After the gap, a failed pass erases the same block again, and a successful pass moves on to the next block.
- R6: A block gets at most MAX_PASS erase pulses. If its last pass still reads a non-blank word, fail rises and fail_blk gives the block index. All mode controls and blk_sel go low, and no later block is erased.
- R7: Only masked blocks are erased, in ascending index order. blk_sel is one-hot or zero at all times.
- R8: After the last block's wait_vexit gap, wr_en stays low for wait_wroff cycles before done rises. done stays high until the next accepted start.
- R9: A start pulse while busy is high is ignored and has no effect on the running job or its result.
- R10: A wait value of 0 gives the same timing as a value of 1.
- R11: A start with an all-zero mask raises done in the next cycle without asserting any mode control.
- R12: In reset and directly after it, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Job start pulse |
| blk_mask | input | NUM_BLK | Blocks to erase |
| blk_first | input | NUM_BLK*ADDR_W | First word address of each block, packed |
| blk_last | input | NUM_BLK*ADDR_W | Last word address of each block, packed |
| wait_pulse | input | WAIT_W | Erase pulse width in cycles |
| wait_hold | input | WAIT_W | Setup hold after the pulse |
| wait_ventry | input | WAIT_W | Verify entry to first dummy write |
| wait_vread | input | WAIT_W | Dummy write to read |
| wait_vexit | input | WAIT_W | Gap after leaving verify mode |
| wait_wroff | input | WAIT_W | Gap after write enable drops |
| wr_en | output | 1 | Write enable for the array |
| erase_setup | output | 1 | Erase setup control |
| erase_pulse | output | 1 | Erase pulse control |
| verify_mode | output | 1 | Erase-verify mode control |
| blk_sel | output | NUM_BLK | One-hot select of the block being erased |
| arr_addr | output | ADDR_W | Array address |
| arr_we | output | 1 | Array write strobe (dummy write) |
| arr_wdata | output | DATA_W | Array write data |
| arr_rdata | input | DATA_W | Array read data at the latched address |
| busy | output | 1 | Job running |
| done | output | 1 | Job completed, all blocks blank |
| fail | output | 1 | Job stopped on a block that did not erase |
| fail_blk | output | BLK_W | Index of the failing block |

## Verification
Each control is due a fixed number of cycles after the previous one. The erase pulse rises one cycle after start is sampled and lasts exactly wait_pulse cycles. The setup hold and the verify entry then follow at exact counts. Dummy writes are spaced wait_vread+2 cycles apart, and done comes exactly wait_wroff cycles after wr_en drops. A monitor samples every output on the falling clock edge and measures each run length from its first to its last cycle, comparing the count with the configured wait (a value of 0 counted as 1). The bench also checks the dummy write addresses, the pulse count of each block and the final outcome. It computes the expected values from a behavioural array whose words need a known number of pulses before they read blank.

// File: rtl/fes_pkg.sv
// Package: shared state encoding for the flash erase-verify sequencer.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package fes_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,     // waiting for start
        ST_ERASE,    // setup and pulse both on
        ST_HOLD,     // pulse off, setup still on
        ST_VENTER,   // verify mode on, before first dummy write
        ST_DUMMY,    // all-ones dummy write latching the address
        ST_VWAIT,    // wait between dummy write and read
        ST_READ,     // sample read data
        ST_VEXIT,    // verify mode off, settle gap
        ST_WROFF,    // write enable off, final gap
        ST_DONE,     // all selected blocks blank
        ST_FAIL      // a block ran out of passes
    } fes_state_t;

endpackage

// File: rtl/fes_wait_timer.sv
// Module: fes_wait_timer
// One down-counter shared by every timed step. Loading N makes expired
// high in the N-th cycle after the load (N = 0 behaves as N = 1).
// Assumes: the owner loads it on every state change.
module fes_wait_timer #(
    parameter int WAIT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    output logic              expired
);

    localparam logic [WAIT_W-1:0] ONE = WAIT_W'(1);

    logic [WAIT_W-1:0] cnt_q;

    // Count down from the loaded value and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign expired = (cnt_q <= ONE);

endmodule

// File: rtl/fes_blk_pick.sv
// Module: fes_blk_pick
// Finds the lowest set bit of a candidate mask and returns its index.
// Assumes: NUM_BLK fits in BLK_W bits of index.
module fes_blk_pick #(
    parameter int NUM_BLK = 4,
    parameter int BLK_W   = 2
) (
    input  logic [NUM_BLK-1:0] cand,
    output logic               found,
    output logic [BLK_W-1:0]   idx
);

    // Scan from the top so the lowest set bit wins.
    always_comb begin
        found = |cand;
        idx   = '0;
        for (int i = NUM_BLK - 1; i >= 0; i--) begin
            if (cand[i]) begin
                idx = BLK_W'(i);
            end
        end
    end

endmodule

// File: rtl/fes_addr_scan.sv
// Module: fes_addr_scan
// Holds the verify address of the current pass and the end address of
// the block, and steps the address by one word per blank read.
// Assumes: first <= last for every block.
module fes_addr_scan #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] first,
    input  logic [ADDR_W-1:0] last,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              at_end
);

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] end_q;

    // Capture the block range at pass start, advance on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            end_q  <= '0;
        end else if (load) begin
            addr_q <= first;
            end_q  <= last;
        end else if (step) begin
            addr_q <= addr_q + ADDR_W'(1);
        end
    end

    assign addr   = addr_q;
    assign at_end = (addr_q == end_q);

endmodule

// File: rtl/flash_erase_seq.sv
// Module: flash_erase_seq
// Erases the masked flash blocks one at a time. Each pass applies an
// erase pulse, releases erase mode, then verifies every word of the block
// with an all-ones dummy write before each read. A non-blank word sends
// the block through another pass, up to MAX_PASS passes. All waits are
// cycle counts on inputs and run on one shared timer.
// Assumes: config inputs are stable while busy; the array returns read
// data for the last dummy-written address combinationally.
module flash_erase_seq #(
    parameter int NUM_BLK  = 4,
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int WAIT_W   = 16,
    parameter int MAX_PASS = 4,
    localparam int BLK_W   = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [NUM_BLK-1:0]        blk_mask,
    input  logic [NUM_BLK*ADDR_W-1:0] blk_first,
    input  logic [NUM_BLK*ADDR_W-1:0] blk_last,
    input  logic [WAIT_W-1:0]         wait_pulse,
    input  logic [WAIT_W-1:0]         wait_hold,
    input  logic [WAIT_W-1:0]         wait_ventry,
    input  logic [WAIT_W-1:0]         wait_vread,
    input  logic [WAIT_W-1:0]         wait_vexit,
    input  logic [WAIT_W-1:0]         wait_wroff,
    output logic                      wr_en,
    output logic                      erase_setup,
    output logic                      erase_pulse,
    output logic                      verify_mode,
    output logic [NUM_BLK-1:0]        blk_sel,
    output logic [ADDR_W-1:0]         arr_addr,
    output logic                      arr_we,
    output logic [DATA_W-1:0]         arr_wdata,
    input  logic [DATA_W-1:0]         arr_rdata,
    output logic                      busy,
    output logic                      done,
    output logic                      fail,
    output logic [BLK_W-1:0]          fail_blk
);

    import fes_pkg::*;

    localparam int PASS_W = $clog2(MAX_PASS + 1);
    localparam logic [PASS_W-1:0] PASS_MAX = PASS_W'(MAX_PASS);
    localparam logic [PASS_W-1:0] PASS_ONE = PASS_W'(1);

    fes_state_t           state_q, state_d;
    logic [BLK_W-1:0]     cur_q;
    logic [NUM_BLK-1:0]   pend_q;
    logic [PASS_W-1:0]    pass_q;
    logic                 retry_q;
    logic [BLK_W-1:0]     fblk_q;

    logic [ADDR_W-1:0]    first_arr [NUM_BLK];
    logic [ADDR_W-1:0]    last_arr  [NUM_BLK];

    logic                 idle_like;
    logic [NUM_BLK-1:0]   pick_in;
    logic                 pick_found;
    logic [BLK_W-1:0]     pick_idx;
    logic [NUM_BLK-1:0]   pick_hot;
    logic [NUM_BLK-1:0]   cur_hot;
    logic                 word_blank;
    logic                 tm_load;
    logic [WAIT_W-1:0]    tm_val;
    logic                 tm_done;
    logic                 scan_load;
    logic                 scan_step;
    logic [ADDR_W-1:0]    scan_addr;
    logic                 scan_end;

    // Split the packed block ranges into per-block words.
    for (genvar g = 0; g < NUM_BLK; g++) begin : g_range
        assign first_arr[g] = blk_first[g*ADDR_W +: ADDR_W];
        assign last_arr[g]  = blk_last[g*ADDR_W +: ADDR_W];
    end

    assign idle_like  = (state_q == ST_IDLE) || (state_q == ST_DONE) ||
                        (state_q == ST_FAIL);
    assign pick_in    = idle_like ? blk_mask : pend_q;
    assign pick_hot   = NUM_BLK'(1) << pick_idx;
    assign cur_hot    = NUM_BLK'(1) << cur_q;
    assign word_blank = &arr_rdata;

    fes_blk_pick #(
        .NUM_BLK (NUM_BLK),
        .BLK_W   (BLK_W)
    ) i_pick (
        .cand  (pick_in),
        .found (pick_found),
        .idx   (pick_idx)
    );

    fes_wait_timer #(
        .WAIT_W (WAIT_W)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tm_load),
        .load_val (tm_val),
        .expired  (tm_done)
    );

    fes_addr_scan #(
        .ADDR_W (ADDR_W)
    ) i_scan (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (scan_load),
        .first  (first_arr[cur_q]),
        .last   (last_arr[cur_q]),
        .step   (scan_step),
        .addr   (scan_addr),
        .at_end (scan_end)
    );

    // Next-state decision for the erase and verify sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (start) begin
                    state_d = pick_found ? ST_ERASE : ST_DONE;
                end
            end
            ST_ERASE:  if (tm_done) state_d = ST_HOLD;
            ST_HOLD:   if (tm_done) state_d = ST_VENTER;
            ST_VENTER: if (tm_done) state_d = ST_DUMMY;
            ST_DUMMY:  state_d = ST_VWAIT;
            ST_VWAIT:  if (tm_done) state_d = ST_READ;
            ST_READ: begin
                if (word_blank) begin
                    state_d = scan_end ? ST_VEXIT : ST_DUMMY;
                end else begin
                    state_d = (pass_q == PASS_MAX) ? ST_FAIL : ST_VEXIT;
                end
            end
            ST_VEXIT: begin
                if (tm_done) begin
                    state_d = (retry_q || pick_found) ? ST_ERASE : ST_WROFF;
                end
            end
            ST_WROFF:  if (tm_done) state_d = ST_DONE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Pick the wait length that belongs to the state being entered.
    always_comb begin
        unique case (state_d)
            ST_ERASE:  tm_val = wait_pulse;
            ST_HOLD:   tm_val = wait_hold;
            ST_VENTER: tm_val = wait_ventry;
            ST_VWAIT:  tm_val = wait_vread;
            ST_VEXIT:  tm_val = wait_vexit;
            ST_WROFF:  tm_val = wait_wroff;
            default:   tm_val = '0;
        endcase
    end

    assign tm_load   = (state_d != state_q);
    assign scan_load = (state_q == ST_HOLD) && (state_d == ST_VENTER);
    assign scan_step = (state_q == ST_READ) && word_blank && !scan_end;

    // State, current block, pending blocks and pass counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            pend_q  <= '0;
            pass_q  <= '0;
            retry_q <= 1'b0;
            fblk_q  <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE, ST_DONE, ST_FAIL: begin
                    if (start) begin
                        fblk_q <= '0;
                        if (pick_found) begin
                            cur_q   <= pick_idx;
                            pend_q  <= blk_mask & ~pick_hot;
                            pass_q  <= PASS_ONE;
                            retry_q <= 1'b0;
                        end
                    end
                end
                ST_READ: begin
                    if (!word_blank) begin
                        if (pass_q == PASS_MAX) begin
                            fblk_q <= cur_q;
                        end else begin
                            pass_q  <= pass_q + PASS_ONE;
                            retry_q <= 1'b1;
                        end
                    end
                end
                ST_VEXIT: begin
                    if (tm_done) begin
                        if (retry_q) begin
                            retry_q <= 1'b0;
                        end else if (pick_found) begin
                            cur_q  <= pick_idx;
                            pend_q <= pend_q & ~pick_hot;
                            pass_q <= PASS_ONE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Moore decode of the mode controls and status from the state.
    always_comb begin
        busy        = !idle_like;
        wr_en       = busy && (state_q != ST_WROFF);
        erase_setup = (state_q == ST_ERASE) || (state_q == ST_HOLD);
        erase_pulse = (state_q == ST_ERASE);
        verify_mode = (state_q == ST_VENTER) || (state_q == ST_DUMMY) ||
                      (state_q == ST_VWAIT)  || (state_q == ST_READ);
        arr_we      = (state_q == ST_DUMMY);
        arr_wdata   = arr_we ? '1 : '0;
        blk_sel     = wr_en ? cur_hot : '0;
        done        = (state_q == ST_DONE);
        fail        = (state_q == ST_FAIL);
    end

    assign arr_addr = scan_addr;
    assign fail_blk = fblk_q;

endmodule

// File: rtl/fes_seq_checks.sv
// Module: fes_seq_checks
// Protocol properties of the sequencer outputs, bound to every instance
// of flash_erase_seq.
// Assumes: synchronous active-low reset on rst_n.
module fes_seq_checks #(
    parameter int NUM_BLK = 4,
    parameter int DATA_W  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic               erase_setup,
    input logic               erase_pulse,
    input logic               verify_mode,
    input logic [NUM_BLK-1:0] blk_sel,
    input logic               arr_we,
    input logic [DATA_W-1:0]  arr_wdata,
    input logic               busy,
    input logic               done,
    input logic               fail
);

    // R1: the pulse only occurs inside erase setup.
    p_pulse_in_setup_r1: assert property (@(posedge clk) disable iff (!rst_n)
        erase_pulse |-> erase_setup);

    // R2: setup is still on in the cycle the pulse drops.
    p_hold_after_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(erase_pulse) |-> erase_setup);

    // R3: erase mode and verify mode never overlap.
    p_modes_apart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(erase_setup && verify_mode));

    // R3: a dummy write happens in verify mode with all-ones data.
    p_dummy_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (verify_mode && (&arr_wdata)));

    // R7: at most one block is selected.
    p_sel_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(blk_sel));

    // R6: fail leaves every mode control low.
    p_fail_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> !(wr_en || erase_setup || erase_pulse || verify_mode ||
                   (blk_sel != '0)));

    // R6: done and fail never together.
    p_done_fail_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    // R8: a job ending in done had write enable low just before.
    p_wren_before_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) && $past(busy)) |-> !$past(wr_en));

endmodule

bind flash_erase_seq fes_seq_checks #(
    .NUM_BLK (NUM_BLK),
    .DATA_W  (DATA_W)
) i_fes_seq_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .erase_setup (erase_setup),
    .erase_pulse (erase_pulse),
    .verify_mode (verify_mode),
    .blk_sel     (blk_sel),
    .arr_we      (arr_we),
    .arr_wdata   (arr_wdata),
    .busy        (busy),
    .done        (done),
    .fail        (fail)
);

// File: tb/test_flash_erase_seq.sv
module test_flash_erase_seq;

    localparam int NB = 4;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int WW = 8;
    localparam int MP = 3;
    localparam int BW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [NB-1:0] blk_mask = '0;
    logic [NB*AW-1:0] blk_first, blk_last;
    logic [WW-1:0] wait_pulse, wait_hold, wait_ventry, wait_vread, wait_vexit, wait_wroff;
    logic wr_en, erase_setup, erase_pulse, verify_mode, arr_we, busy, done, fail;
    logic [NB-1:0] blk_sel;
    logic [AW-1:0] arr_addr;
    logic [DW-1:0] arr_wdata, arr_rdata;
    logic [BW-1:0] fail_blk;

    int w_pulse, w_hold, w_ventry, w_vread, w_vexit, w_wroff;
    int bfirst [NB];
    int blast  [NB];
    int need [256];
    int pulses_done [16];
    int obs_pulses [NB];
    int exp_pulses [NB];
    int obs_writes, exp_writes, exp_fblk;
    bit exp_fail;
    int checks = 0;
    int errs = 0;
    int cycles = 0;
    logic [AW-1:0] lat_q;

    always #10 clk = ~clk;

    flash_erase_seq #(
        .NUM_BLK (NB), .ADDR_W (AW), .DATA_W (DW), .WAIT_W (WW), .MAX_PASS (MP)
    ) i_flash_erase_seq (
        .clk, .rst_n, .start, .blk_mask, .blk_first, .blk_last,
        .wait_pulse, .wait_hold, .wait_ventry, .wait_vread, .wait_vexit, .wait_wroff,
        .wr_en, .erase_setup, .erase_pulse, .verify_mode, .blk_sel,
        .arr_addr, .arr_we, .arr_wdata, .arr_rdata,
        .busy, .done, .fail, .fail_blk
    );

    always_comb begin
        for (int b = 0; b < NB; b++) begin
            blk_first[b*AW +: AW] = AW'(bfirst[b]);
            blk_last[b*AW +: AW]  = AW'(blast[b]);
        end
        wait_pulse  = WW'(w_pulse);
        wait_hold   = WW'(w_hold);
        wait_ventry = WW'(w_ventry);
        wait_vread  = WW'(w_vread);
        wait_vexit  = WW'(w_vexit);
        wait_wroff  = WW'(w_wroff);
    end

    // Behavioural array: dummy write latches address; a word is blank once
    // its block has had at least need[] erase pulses.
    always @(posedge clk) if (arr_we) lat_q <= arr_addr;
    always_comb begin
        if (need[lat_q] <= pulses_done[lat_q >> 4]) arr_rdata = 16'hFFFF;
        else arr_rdata = ~(16'h1 << lat_q[3:0]);
    end

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected outcome from the requirements: per block, pass k scans until
    // the first word needing more than k pulses.
    task automatic calc_expect(input logic [NB-1:0] m);
        exp_fail = 0; exp_writes = 0; exp_fblk = 0;
        for (int b = 0; b < NB; b++) exp_pulses[b] = 0;
        for (int b = 0; b < NB; b++) begin
            if (m[b] && !exp_fail) begin
                for (int k = 1; k <= MP; k++) begin
                    bit bad = 0;
                    exp_pulses[b]++;
                    for (int a = bfirst[b]; a <= blast[b]; a++) begin
                        exp_writes++;
                        if (need[a] > k) begin bad = 1; break; end
                    end
                    if (!bad) break;
                    if (k == MP) begin exp_fail = 1; exp_fblk = b; end
                end
            end
        end
    endtask

    // Monitor: measures run lengths of each control phase at negedge.
    bit mon_on = 0;
    bit p_ep, p_hold, p_vm, p_cev, p_cswe, seen_we;
    int run_ep, run_hold, run_sev, since_we, run_cev, run_cswe, cur_b, last_b, exp_addr;
    always @(negedge clk) begin
        if (mon_on) begin
            bit hold_c, cev_c, cswe_c;
            hold_c = erase_setup && !erase_pulse;
            cev_c  = busy && wr_en && !erase_setup && !verify_mode;
            cswe_c = busy && !wr_en;
            chk($onehot0(blk_sel), "R7", blk_sel, 0);
            if (erase_pulse && !p_ep) begin
                chk($onehot(blk_sel), "R1", blk_sel, 1);
                cur_b = 0;
                for (int b = 0; b < NB; b++) if (blk_sel[b]) cur_b = b;
                chk(blk_mask[cur_b] && cur_b >= last_b, "R7", cur_b, last_b);
                last_b = cur_b;
                obs_pulses[cur_b]++;
            end
            if (erase_pulse) run_ep++;
            else if (p_ep) begin
                chk(run_ep == eff(w_pulse), "R1", run_ep, eff(w_pulse));
                run_ep = 0;
                pulses_done[cur_b]++;
            end
            if (hold_c) run_hold++;
            else if (p_hold) begin
                chk(run_hold == eff(w_hold), "R2", run_hold, eff(w_hold));
                run_hold = 0;
            end
            if (verify_mode && !p_vm) begin
                exp_addr = bfirst[cur_b]; seen_we = 0; run_sev = 0; since_we = 0;
            end
            if (verify_mode) begin
                if (arr_we) begin
                    chk(arr_wdata == 16'hFFFF, "R3", arr_wdata, 16'hFFFF);
                    chk(int'(arr_addr) == exp_addr, "R3", arr_addr, exp_addr);
                    if (!seen_we) chk(run_sev == eff(w_ventry), "R3", run_sev, eff(w_ventry));
                    else chk(since_we == eff(w_vread) + 1, "R4", since_we, eff(w_vread) + 1);
                    exp_addr++; obs_writes++; seen_we = 1; since_we = 0;
                end else if (!seen_we) run_sev++;
                else since_we++;
            end else if (p_vm) begin
                chk(since_we == eff(w_vread) + 1, "R4", since_we, eff(w_vread) + 1);
            end
            if (cev_c) run_cev++;
            else if (p_cev) begin
                chk(run_cev == eff(w_vexit), "R5", run_cev, eff(w_vexit));
                run_cev = 0;
            end
            if (cswe_c) run_cswe++;
            else if (p_cswe) begin
                chk(done && run_cswe == eff(w_wroff), "R8", run_cswe, eff(w_wroff));
                run_cswe = 0;
            end
            p_ep = erase_pulse; p_hold = hold_c; p_vm = verify_mode;
            p_cev = cev_c; p_cswe = cswe_c;
        end
    end

    task automatic layout(input bit rnd);
        for (int b = 0; b < NB; b++) begin
            bfirst[b] = b * 16;
            blast[b]  = b * 16 + (rnd ? int'($urandom % 16) : 15);
        end
        for (int a = 0; a < 256; a++) begin
            int r;
            r = rnd ? int'($urandom % 16) : 0;
            need[a] = (r < 8) ? 0 : (r < 13) ? 1 : (r < 15) ? 2 : 3;
        end
    endtask

    task automatic set_waits(input int p, input int h, input int e, input int r,
                             input int x, input int o);
        w_pulse = p; w_hold = h; w_ventry = e; w_vread = r; w_vexit = x; w_wroff = o;
    endtask

    task automatic do_run(input logic [NB-1:0] m, input bit poke);
        int n;
        calc_expect(m);
        for (int b = 0; b < 16; b++) pulses_done[b] = 0;
        for (int b = 0; b < NB; b++) obs_pulses[b] = 0;
        obs_writes = 0; last_b = 0;
        @(negedge clk); blk_mask = m; start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (m == '0) begin
            chk(done && !wr_en && !erase_setup && !verify_mode, "R11", done, 1);
        end
        if (poke && m != '0) begin
            repeat (3) @(negedge clk);
            chk(busy, "R9", busy, 1);
            blk_mask = '1; start = 1'b1;
            @(negedge clk); start = 1'b0; blk_mask = m;
        end
        n = 0;
        while (!(done || fail) && n < 20000) begin @(negedge clk); n++; end
        @(negedge clk);
        chk(done == !exp_fail, "R8", done, !exp_fail);
        chk(fail == exp_fail, "R6", fail, exp_fail);
        if (exp_fail) chk(fail_blk == BW'(exp_fblk), "R6", fail_blk, exp_fblk);
        for (int b = 0; b < NB; b++)
            chk(obs_pulses[b] == exp_pulses[b], poke ? "R9" : "R5", obs_pulses[b], exp_pulses[b]);
        chk(obs_writes == exp_writes, "R3", obs_writes, exp_writes);
        chk(!(wr_en || erase_setup || erase_pulse || verify_mode || busy) && blk_sel == '0,
            exp_fail ? "R6" : "R8", {wr_en, erase_setup, erase_pulse, verify_mode, busy}, 0);
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        forever begin
            @(posedge clk); cycles++;
            if (cycles > 150000) begin
                chk(0, "watchdog", cycles, 150000);
                $display("Result: errors=%0d of %0d checks", errs, checks);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd4242));
        set_waits(1, 1, 1, 1, 1, 1);
        layout(0);
        for (int b = 0; b < 16; b++) pulses_done[b] = 0;
        lat_q = '0;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk({wr_en, erase_setup, erase_pulse, verify_mode, arr_we, busy, done, fail} == 8'h0
            && blk_sel == '0, "R12", {wr_en, erase_setup, erase_pulse, verify_mode, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !fail && !wr_en, "R12", {busy, done, fail, wr_en}, 0);
        mon_on = 1;
        // Directed: two blocks, word needing two pulses (R5, R7)
        need[5] = 2;
        do_run(4'b0101, 0);
        // R10: zero waits behave as one
        set_waits(0, 0, 0, 0, 0, 0);
        layout(0); need[63] = 1;
        do_run(4'b1000, 0);
        // R6: block 1 exceeds the cap, block 2 untouched
        set_waits(2, 3, 2, 1, 2, 3);
        layout(0); need[16 + 7] = MP + 1; need[40] = 1;
        do_run(4'b0111, 0);
        // R11: empty mask
        do_run(4'b0000, 0);
        // R9: start while busy ignored
        layout(0); need[2] = 2; need[50] = 3;
        do_run(4'b1001, 1);
        // R5: only the last word of a block fails twice
        layout(0); need[15] = 3;
        do_run(4'b0001, 0);
        // Random runs
        for (int i = 0; i < 25; i++) begin
            set_waits($urandom % 5, $urandom % 5, $urandom % 5, $urandom % 5,
                      $urandom % 5, $urandom % 5);
            layout(1);
            if ($urandom % 4 == 0) need[($urandom % NB) * 16] = MP + 1;
            do_run(NB'($urandom), ($urandom % 3) == 0);
        end
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule